// File: doc/BRIEF.md
# Serial Port Host Control Registers

This block is the host-facing control section of a 16550-class serial port. It decodes host register accesses from a 3-bit offset and the divisor-latch select, and it holds the four-bit interrupt enable mask. It accepts writes to the write-only FIFO control register and owns the receive and transmit byte queues that sit between the host and the serial shifters, including their occupancy counters. Interrupt requests from four sources are masked and combined into one interrupt line.

Received bytes arrive from the receive shifter as one-cycle strobes and are read by the host at offset 0. Transmit bytes written by the host at offset 0 are handed to the transmit shifter one at a time, only when the shifter reports that it has finished the previous byte. In non-FIFO mode each direction holds a single byte, which behaves as the classic double-buffered holding register. In FIFO mode each direction queues up to `DEPTH` bytes, and a receive trigger level selects how full the receive queue must be before it raises a data interrupt.

The serial shifters, baud generation, interrupt identification and priority, modem-line logic and DMA are outside this block.

Top module: `sio_host_ctrl`

## Requirements
- R1: After reset the interrupt mask is 0, FIFO mode is off, both queues are empty and `irq` is low.
- R2: A write at offset 1 with `bus_dlab`=0 stores `bus_wdata[3:0]` as the interrupt mask. A read there returns the mask with bits 7:4 as 0. With `bus_dlab`=1 a write at offset 1 leaves the mask unchanged.
- R3: `irq` is the OR of four masked conditions. Mask bit 0 selects receive data ready. Mask bit 1 selects transmit queue empty. Mask bit 2 selects `src_line_status`. Mask bit 3 selects `src_modem_status`. With the mask at 0, `irq` stays low whatever the sources do.
- R4: The FIFO control register is written at offset 2 whatever `bus_dlab` is. A read at offset 2 returns 8'h00 and never the stored control value.
- R5: A FIFO control write with bit 0 = 1 turns FIFO mode on (`fifo_mode`=1). A write with bit 0 = 0 turns it off and empties both queues.
- R6: Bits 7:1 of a FIFO control write act only when bit 0 of the same write is 1. A write with bit 0 = 0 flushes both queues, whatever bits 2:1 hold.
- R7: A FIFO control write with bits 1:0 = 2'b11 empties the receive queue only. The bit does not stay set: a byte that arrives afterwards is kept, and a later write with bit 1 = 0 does not flush.
- R8: A FIFO control write with bits 2 and 0 set empties the transmit queue only and does not stay set.
- R9: In FIFO mode, bits 7:6 pick the receive trigger level (00 gives 1 byte, 01 gives 4, 10 gives 8, 11 gives 14), and receive data ready means count >= trigger. `src_rx_timeout` also counts as receive data ready, but only in FIFO mode. In non-FIFO mode, receive data ready means one byte is held.
- R10: In non-FIFO mode each queue holds at most one byte. In both modes a received byte or a host transmit write that finds its queue full is discarded.
- R11: Offset 0 with `bus_dlab`=0 reads and removes the oldest received byte, and a write there queues a transmit byte. With `bus_dlab`=1, offset 0 neither queues nor removes a byte and reads 8'h00.
- R12: `tx_load` is high, with `tx_load_byte` holding the oldest queued byte, exactly when `tx_shift_idle` is 1 and the transmit queue is not empty. The byte is removed at that clock edge, and bytes leave in write order.
- R13: FIFO control bit 3 (the DMA mode select) has no effect.
- R14: Each queue holds at most `DEPTH` bytes. In FIFO mode the 17th received byte is discarded and order is kept.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | 3 | Register offset |
| bus_dlab | input | 1 | Divisor-latch select |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe (a read at offset 0 removes a byte) |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, combinational from the offset |
| rx_strobe | input | 1 | Receive shifter delivers a byte |
| rx_byte | input | 8 | Delivered byte |
| tx_shift_idle | input | 1 | Transmit shifter can take a byte |
| tx_load | output | 1 | Transmit byte handed over this cycle |
| tx_load_byte | output | 8 | Byte handed over |
| src_rx_timeout | input | 1 | Receive timeout condition |
| src_line_status | input | 1 | Line status error condition |
| src_modem_status | input | 1 | Modem status change condition |
| irq | output | 1 | Combined interrupt request |
| fifo_mode | output | 1 | FIFO mode is active |
| rx_count | output | $clog2(DEPTH+1) | Receive queue occupancy |
| tx_count | output | $clog2(DEPTH+1) | Transmit queue occupancy |

## Verification
The queues are exercised with single bytes in non-FIFO mode, which shows whether the one-slot limit and the discard on full hold, and with runs that fill the receive queue past capacity, which shows both the ordering and the 16-entry cap. The interrupt line is driven by walking the receive count across each of the four trigger levels, so an off-by-one comparison or a swapped level code shows up as a wrong `irq` value at a known count. FIFO control writes combine the enable bit with the flush and DMA bits in turn, which separates a selective flush from a full flush and a self-clearing flush from a sticky one. Transmit hand-over is tried with the shifter held busy and then released one cycle at a time, which shows whether a byte is lost or sent twice.

// File: rtl/sio_ctrl_pkg.sv
package sio_ctrl_pkg;

   localparam logic [2:0] OFS_DATA = 3'd0;
   localparam logic [2:0] OFS_IEN  = 3'd1;
   localparam logic [2:0] OFS_FCTL = 3'd2;

   // interrupt mask bit positions
   localparam int IEN_RXRDY = 0;
   localparam int IEN_TXMT  = 1;
   localparam int IEN_LSTAT = 2;
   localparam int IEN_MSTAT = 3;
   localparam int N_SRC     = 4;

   typedef struct packed {
      logic [1:0] trig;    // 7:6
      logic [1:0] rsvd;    // 5:4
      logic       dma_sel; // 3, no effect
      logic       tx_clr;  // 2
      logic       rx_clr;  // 1
      logic       ena;     // 0
   } fctl_t;

   function automatic int unsigned trig_bytes(input logic [1:0] code);
      case (code)
         2'b00:   return 1;
         2'b01:   return 4;
         2'b10:   return 8;
         default: return 14;
      endcase
   endfunction

endpackage

// File: rtl/sio_byte_queue.sv
module sio_byte_queue #(
   parameter int W     = 8,
   parameter int DEPTH = 16,
   localparam int AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
   localparam int CW   = $clog2(DEPTH + 1)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          flush,
   input  logic          one_slot,
   input  logic          push,
   input  logic [W-1:0]  din,
   input  logic          pop,
   output logic [W-1:0]  dout,
   output logic [CW-1:0] count
);

   logic [W-1:0]  mem [DEPTH];
   logic [AW-1:0] wr_ptr, rd_ptr, wr_nxt, rd_nxt;
   logic [CW-1:0] cap;
   logic          full, acc_push, acc_pop;

   assign cap      = one_slot ? CW'(1) : CW'(DEPTH);
   assign full     = (count >= cap);
   assign acc_push = push && !full;
   assign acc_pop  = pop && (count != '0);
   assign dout     = mem[rd_ptr];

   generate
      if ((DEPTH & (DEPTH - 1)) == 0) begin : g_wrap_pow2
         assign wr_nxt = wr_ptr + AW'(1);
         assign rd_nxt = rd_ptr + AW'(1);
      end else begin : g_wrap_cmp
         assign wr_nxt = (wr_ptr == AW'(DEPTH - 1)) ? '0 : wr_ptr + AW'(1);
         assign rd_nxt = (rd_ptr == AW'(DEPTH - 1)) ? '0 : rd_ptr + AW'(1);
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (acc_push && !flush) mem[wr_ptr] <= din;
   end

   always_ff @(posedge clk) begin
      if (!rst_n || flush) begin
         wr_ptr <= '0;
         rd_ptr <= '0;
         count  <= '0;
      end else begin
         if (acc_push) wr_ptr <= wr_nxt;
         if (acc_pop)  rd_ptr <= rd_nxt;
         case ({acc_push, acc_pop})
            2'b10:   count <= count + CW'(1);
            2'b01:   count <= count - CW'(1);
            default: count <= count;
         endcase
      end
   end

   assert_count_bound_R14 : assert property (@(posedge clk) disable iff (!rst_n)
      count <= CW'(DEPTH));
   assert_one_slot_R10 : assert property (@(posedge clk) disable iff (!rst_n)
      (one_slot && $stable(one_slot)) |-> count <= CW'(1));
   assert_flush_empties_R7 : assert property (@(posedge clk) disable iff (!rst_n)
      flush |=> count == '0);

endmodule

// File: rtl/sio_irq_gate.sv
module sio_irq_gate #(
   parameter int N = 4
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [N-1:0] en,
   input  logic [N-1:0] cond,
   output logic         irq
);

   logic [N-1:0] req;

   generate
      for (genvar i = 0; i < N; i++) begin : g_src
         assign req[i] = en[i] & cond[i];
      end
   endgenerate

   assign irq = |req;

   assert_quiet_mask_R3 : assert property (@(posedge clk) disable iff (!rst_n)
      (en == '0) |-> !irq);

endmodule

// File: rtl/sio_host_ctrl.sv
module sio_host_ctrl
   import sio_ctrl_pkg::*;
#(
   parameter int DEPTH = 16,
   localparam int CW   = $clog2(DEPTH + 1)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic [2:0]    bus_addr,
   input  logic          bus_dlab,
   input  logic          bus_wr,
   input  logic          bus_rd,
   input  logic [7:0]    bus_wdata,
   output logic [7:0]    bus_rdata,
   input  logic          rx_strobe,
   input  logic [7:0]    rx_byte,
   input  logic          tx_shift_idle,
   output logic          tx_load,
   output logic [7:0]    tx_load_byte,
   input  logic          src_rx_timeout,
   input  logic          src_line_status,
   input  logic          src_modem_status,
   output logic          irq,
   output logic          fifo_mode,
   output logic [CW-1:0] rx_count,
   output logic [CW-1:0] tx_count
);

   initial begin : param_check
      assert (DEPTH >= 14) else $error("DEPTH must cover the largest trigger level");
   end

   logic [N_SRC-1:0] ien_q;
   logic [1:0]       trig_q;
   logic             fmode_q;
   fctl_t            fw;
   logic             ien_wr, fctl_wr, thr_wr, rbr_rd;
   logic             rx_flush, tx_flush, rx_ready;
   logic [7:0]       rx_head;
   logic [N_SRC-1:0] cond;

   assign fw      = fctl_t'(bus_wdata);
   assign ien_wr  = bus_wr && (bus_addr == OFS_IEN) && !bus_dlab;
   assign fctl_wr = bus_wr && (bus_addr == OFS_FCTL);
   assign thr_wr  = bus_wr && (bus_addr == OFS_DATA) && !bus_dlab;
   assign rbr_rd  = bus_rd && (bus_addr == OFS_DATA) && !bus_dlab;

   // enable bit qualifies the remaining fields; a clear enable flushes both
   assign rx_flush = fctl_wr && (!fw.ena || fw.rx_clr);
   assign tx_flush = fctl_wr && (!fw.ena || fw.tx_clr);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ien_q   <= '0;
         fmode_q <= 1'b0;
         trig_q  <= 2'b00;
      end else begin
         if (ien_wr) ien_q <= bus_wdata[N_SRC-1:0];
         if (fctl_wr) begin
            fmode_q <= fw.ena;
            if (fw.ena) trig_q <= fw.trig;
         end
      end
   end

   sio_byte_queue #(.W(8), .DEPTH(DEPTH)) u_rxq (
      .clk(clk), .rst_n(rst_n), .flush(rx_flush), .one_slot(!fmode_q),
      .push(rx_strobe), .din(rx_byte), .pop(rbr_rd),
      .dout(rx_head), .count(rx_count));

   sio_byte_queue #(.W(8), .DEPTH(DEPTH)) u_txq (
      .clk(clk), .rst_n(rst_n), .flush(tx_flush), .one_slot(!fmode_q),
      .push(thr_wr), .din(bus_wdata), .pop(tx_load),
      .dout(tx_load_byte), .count(tx_count));

   assign tx_load = tx_shift_idle && (tx_count != '0);

   always_comb begin
      bus_rdata = 8'h00;
      if (!bus_dlab && bus_addr == OFS_DATA) bus_rdata = rx_head;
      if (!bus_dlab && bus_addr == OFS_IEN)  bus_rdata = {{(8-N_SRC){1'b0}}, ien_q};
   end

   assign rx_ready = fmode_q ? ((32'(rx_count) >= trig_bytes(trig_q)) || src_rx_timeout)
                             : (rx_count != '0);

   always_comb begin
      cond            = '0;
      cond[IEN_RXRDY] = rx_ready;
      cond[IEN_TXMT]  = (tx_count == '0);
      cond[IEN_LSTAT] = src_line_status;
      cond[IEN_MSTAT] = src_modem_status;
   end

   sio_irq_gate #(.N(N_SRC)) u_irq (
      .clk(clk), .rst_n(rst_n), .en(ien_q), .cond(cond), .irq(irq));

   assign fifo_mode = fmode_q;

   assert_fctl_off_R5 : assert property (@(posedge clk) disable iff (!rst_n)
      (fctl_wr && !bus_wdata[0]) |=> (!fifo_mode && rx_count == '0 && tx_count == '0));
   assert_ien_upper_R2 : assert property (@(posedge clk) disable iff (!rst_n)
      (!bus_dlab && bus_addr == OFS_IEN) |-> bus_rdata[7:4] == 4'h0);
   assert_fctl_unreadable_R4 : assert property (@(posedge clk) disable iff (!rst_n)
      (bus_addr == OFS_FCTL) |-> bus_rdata == 8'h00);
   assert_tx_handover_R12 : assert property (@(posedge clk) disable iff (!rst_n)
      (tx_load && !thr_wr && !tx_flush) |=> tx_count == $past(tx_count) - CW'(1));

endmodule

// File: tb/test_sio_host_ctrl.sv
module test_sio_host_ctrl;

   localparam int DEPTH = 16;
   localparam int CW    = $clog2(DEPTH + 1);

   logic clk = 1'b0, rst_n = 1'b0;
   logic [2:0] bus_addr = '0;
   logic bus_dlab = 0, bus_wr = 0, bus_rd = 0;
   logic [7:0] bus_wdata = '0, bus_rdata;
   logic rx_strobe = 0;
   logic [7:0] rx_byte = '0;
   logic tx_shift_idle = 0, tx_load;
   logic [7:0] tx_load_byte;
   logic src_rx_timeout = 0, src_line_status = 0, src_modem_status = 0;
   logic irq, fifo_mode;
   logic [CW-1:0] rx_count, tx_count;

   int n_cmp = 0, n_bad = 0;
   bit done = 0;
   bit m_fifo = 0;
   byte unsigned rx_exp[$], tx_exp[$];

   always #10 clk = ~clk; // 50 MHz

   sio_host_ctrl #(.DEPTH(DEPTH)) i_sio_host_ctrl (.*);

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      n_cmp++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s: actual %0h expected %0h", req, act, exp);
      end
   endtask

   task automatic eq(input string req, input int act, input int exp);
      chk(act == exp, req, act, exp);
   endtask

   function automatic int cap();
      return m_fifo ? DEPTH : 1;
   endfunction

   task automatic wr(input logic [2:0] a, input logic d, input logic [7:0] v);
      @(negedge clk);
      bus_addr = a; bus_dlab = d; bus_wdata = v; bus_wr = 1;
      @(negedge clk);
      bus_wr = 0; bus_dlab = 0;
   endtask

   task automatic rd(input logic [2:0] a, input logic d, output logic [7:0] v);
      @(negedge clk);
      bus_addr = a; bus_dlab = d; bus_rd = 1;
      #1 v = bus_rdata;
      @(negedge clk);
      bus_rd = 0; bus_dlab = 0;
   endtask

   // driver: a queued byte is expected back at the host read
   task automatic rx_in(input byte unsigned b);
      if (rx_exp.size() < cap()) rx_exp.push_back(b);
      @(negedge clk);
      rx_strobe = 1; rx_byte = b;
      @(negedge clk);
      rx_strobe = 0;
   endtask

   task automatic tx_in(input byte unsigned b);
      if (tx_exp.size() < cap()) tx_exp.push_back(b);
      wr(3'd0, 0, b);
   endtask

   task automatic rx_out(input string req);
      logic [7:0] v;
      byte unsigned e;
      e = (rx_exp.size() != 0) ? rx_exp.pop_front() : 8'h00;
      rd(3'd0, 0, v);
      eq(req, v, e);
   endtask

   task automatic drain();
      @(negedge clk); tx_shift_idle = 1;
      @(negedge clk); tx_shift_idle = 0;
   endtask

   task automatic fctl(input logic [7:0] v);
      wr(3'd2, 1'b0, v);
      if (!v[0]) begin
         m_fifo = 0; rx_exp.delete(); tx_exp.delete();
      end else begin
         m_fifo = 1;
         if (v[1]) rx_exp.delete();
         if (v[2]) tx_exp.delete();
      end
   endtask

   // monitor: every hand-over must match the oldest expected transmit byte
   initial begin
      forever begin
         @(negedge clk);
         #5;
         if (tx_load) begin
            if (tx_exp.size() == 0) chk(0, "R12 unexpected load", tx_load_byte, 0);
            else eq("R12 load order", tx_load_byte, tx_exp.pop_front());
         end
      end
   end

   task automatic finish_run();
      if (!done) begin
         done = 1;
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
         $finish;
      end
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      n_cmp++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
   end

   initial begin
      logic [7:0] v;
      repeat (3) @(negedge clk);
      rst_n = 1;
      @(negedge clk);
      // R1
      eq("R1 rx_count", rx_count, 0);
      eq("R1 tx_count", tx_count, 0);
      eq("R1 fifo_mode", fifo_mode, 0);
      eq("R1 irq", irq, 0);
      rd(3'd1, 0, v); eq("R1 mask", v, 0);

      // R2 / R3 mask access
      wr(3'd1, 0, 8'hFF);
      rd(3'd1, 0, v); eq("R2 mask readback", v, 8'h0F);
      wr(3'd1, 1, 8'h00);
      rd(3'd1, 0, v); eq("R2 dlab write ignored", v, 8'h0F);
      eq("R3 tx empty raises irq", irq, 1);
      wr(3'd1, 0, 8'h00);
      src_line_status = 1; src_modem_status = 1;
      @(negedge clk);
      eq("R3 zero mask quiet", irq, 0);
      src_line_status = 0; src_modem_status = 0;

      // R10 / R11 non-FIFO single slot
      rx_in(8'h11); rx_in(8'h22);
      eq("R10 one slot rx", rx_count, 1);
      rd(3'd0, 1, v); eq("R11 dlab read zero", v, 0);
      eq("R11 dlab read keeps byte", rx_count, 1);
      rx_out("R11 rx read");
      eq("R11 read removes", rx_count, 0);
      wr(3'd1, 0, 8'h01);
      src_rx_timeout = 1;
      @(negedge clk);
      eq("R9 timeout ignored non-FIFO", irq, 0);
      src_rx_timeout = 0;
      rx_in(8'h33);
      eq("R9 one byte ready non-FIFO", irq, 1);
      rx_out("R11 rx read 2");
      eq("R9 irq clears", irq, 0);
      tx_in(8'hA5); tx_in(8'h5A);
      eq("R10 one slot tx", tx_count, 1);
      wr(3'd0, 1, 8'h99);
      eq("R11 dlab write no queue", tx_count, 1);
      drain();
      eq("R12 tx drained", tx_count, 0);

      // R4 / R5 / R9 FIFO mode, trigger levels
      wr(3'd2, 1, 8'h41); m_fifo = 1;
      eq("R5 fifo on (R4 dlab ignored)", fifo_mode, 1);
      rd(3'd2, 0, v); eq("R4 offset 2 reads zero", v, 0);
      for (int i = 0; i < 3; i++) rx_in(8'h40 + 8'(i));
      eq("R9 below trigger 4", irq, 0);
      rx_in(8'h43);
      eq("R9 at trigger 4", irq, 1);
      fctl(8'h81);
      eq("R9 below trigger 8", irq, 0);
      eq("R9 trigger write no flush", rx_count, 4);
      for (int i = 4; i < 8; i++) rx_in(8'h40 + 8'(i));
      eq("R9 at trigger 8", irq, 1);
      fctl(8'hC1);
      eq("R9 below trigger 14", irq, 0);
      for (int i = 8; i < 14; i++) rx_in(8'h40 + 8'(i));
      eq("R9 at trigger 14", irq, 1);
      for (int i = 14; i < 17; i++) rx_in(8'h40 + 8'(i));
      eq("R14 capacity", rx_count, DEPTH);
      for (int i = 0; i < 16; i++) rx_out("R14 rx order");
      eq("R14 emptied", rx_count, 0);
      src_rx_timeout = 1;
      @(negedge clk);
      eq("R9 timeout in FIFO mode", irq, 1);
      src_rx_timeout = 0;

      // R7 / R8 / R13 selective, self-clearing flush
      for (int i = 0; i < 3; i++) rx_in(8'h60 + 8'(i));
      for (int i = 0; i < 8; i++) tx_in(8'h80 + 8'(i));
      fctl(8'h03);
      eq("R7 rx flushed", rx_count, 0);
      eq("R7 tx kept", tx_count, 8);
      rx_in(8'h77);
      eq("R7 later byte kept", rx_count, 1);
      fctl(8'h01);
      eq("R7 self-clearing", rx_count, 1);
      fctl(8'h05);
      eq("R8 tx flushed", tx_count, 0);
      eq("R8 rx kept", rx_count, 1);
      fctl(8'h09);
      eq("R13 dma bit no flush", rx_count, 1);
      eq("R13 dma bit mode kept", fifo_mode, 1);
      rx_out("R7 kept byte value");

      // R12 hand-over
      for (int i = 0; i < 3; i++) tx_in(8'hC0 + 8'(i));
      repeat (2) @(negedge clk);
      eq("R12 busy shifter holds", tx_count, 3);
      for (int i = 0; i < 3; i++) drain();
      eq("R12 all handed over", tx_count, 0);
      eq("R12 none lost", tx_exp.size(), 0);

      // R5 / R6 disable with other bits set
      rx_in(8'h55); tx_in(8'hAA);
      fctl(8'h06);
      eq("R5 fifo off", fifo_mode, 0);
      eq("R6 rx flushed on disable", rx_count, 0);
      eq("R6 tx flushed on disable", tx_count, 0);

      // R3 remaining sources
      wr(3'd1, 0, 8'h04); src_line_status = 1;
      @(negedge clk); eq("R3 line status", irq, 1);
      src_line_status = 0;
      @(negedge clk); eq("R3 line status low", irq, 0);
      wr(3'd1, 0, 8'h08); src_modem_status = 1;
      @(negedge clk); eq("R3 modem status", irq, 1);
      src_modem_status = 0;

      repeat (2) @(negedge clk);
      finish_run();
   end

endmodule